// File: doc/BRIEF.md
# Sliding-Window Mean-Square Level Estimator

This block turns a stream of signed converter samples of a current waveform into a running power level that a regulator can use. Each accepted sample is squared. The squares go into an equal-weight averaging window that holds the most recent `WIN_LEN` of them. The window is kept as a running sum: each new square is added and the square that has just left the window is taken away, so the cost per sample stays the same for any window length. The running mean-square comes out on every sample, together with a flag that tells when the window has filled.

A slower control loop reads a decimated copy of the level. Once every `DECIM` accepted samples the block pulses a strobe and latches a level for the loop. A build parameter picks the latched value: the mean-square itself, or its integer square root (an RMS amplitude). With the default sizes (a 120-sample window and 200 samples between strobes at a 200 kHz sample rate), each latched value comes from a window that is already settled.

Top module: `msq_level_est`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `level_mean` is 0, `level_valid` is 0, `dec_stb` is 0 and `dec_level` is 0. The sample history is treated as empty.
- R2: Each sample accepted with `smp_valid` high is read as a two's-complement value and squared. `level_mean` equals floor(S / WIN_LEN), where S is the sum of the squares of the most recent WIN_LEN accepted samples. The value is updated at the fourth rising edge after the edge that accepts the sample, counting that edge as the first.
- R3: While fewer than WIN_LEN samples have been accepted since reset, the missing window entries count as zero, so S is the sum of the squares received so far and is still divided by WIN_LEN.
- R4: `level_valid` is 0 until the WIN_LEN-th sample after reset has reached `level_mean`. From then on it stays 1 until the next reset.
- R5: On a cycle with `smp_valid` low, `smp_data` is ignored. It changes neither `level_mean` nor the strobe sequence.
- R6: The accumulator cannot overflow. A window full of the most negative input value gives a `level_mean` of exactly 2^(2·SAMPLE_W−2).
- R7: `dec_stb` is a one-cycle pulse on the cycle after `level_mean` takes the value for every DECIM-th accepted sample since reset.
- R8: When `dec_stb` pulses, `dec_level` takes floor(sqrt(level_mean)) if USE_SQRT is 1, or `level_mean` if USE_SQRT is 0, zero-extended in both cases. The `level_mean` used is the value held before that update. `dec_level` holds between pulses.
- R9: Samples accepted on consecutive clock cycles are all taken into the window, with no sample lost.
- R10: After a step to a constant input amplitude A, `level_mean` equals A·A exactly once WIN_LEN samples of the new amplitude have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A new sample is present on `smp_data` |
| smp_data | input | SAMPLE_W | Signed two's-complement sample |
| level_mean | output | 2·SAMPLE_W | Running windowed mean-square |
| level_valid | output | 1 | Window has been filled since reset |
| dec_stb | output | 1 | One-cycle strobe every DECIM samples |
| dec_level | output | 2·SAMPLE_W | Latched level for the slow loop (root or mean) |

## Verification
The bench builds two copies of the block with SAMPLE_W=6, WIN_LEN=5 and DECIM=7: one with the square-root output and one without. Both see the same stimulus. With a 6-bit input, every input code from −32 to 31 can be sent through the window. This covers the most negative code, whose square is the largest and which sets the accumulator bound. The short window and the period of 7 samples, which does not divide evenly by the window length, let the bench reach the window filling up, wrap-around of the delay line, strobes landing at every phase of the window, back-to-back bursts and a reset in the middle of a run, all within a few hundred samples. Each result is compared with a sum, an integer division and a square root that the bench computes itself.

// File: rtl/msq_pkg.sv
package msq_pkg;

  // Accumulator width: room for win_len squares of a w-bit signed value.
  function automatic int unsigned acc_width(int unsigned w, int unsigned win_len);
    return 2 * w + $clog2(win_len + 1);
  endfunction

  // Output selection for the decimated level.
  typedef enum logic {
    OUT_MEAN = 1'b0,
    OUT_ROOT = 1'b1
  } out_sel_e;

endpackage

// File: rtl/msq_square_stage.sv
module msq_square_stage #(
  parameter int unsigned SAMPLE_W = 16,
  localparam int unsigned SQ_W = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                sq_valid,
  output logic [SQ_W-1:0]     sq_data
);

  logic signed [SQ_W-1:0] prod;

  always_comb begin
    prod = $signed(in_data) * $signed(in_data);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_valid <= 1'b0;
      sq_data  <= '0;
    end else begin
      sq_valid <= in_valid;
      if (in_valid) begin
        sq_data <= prod;
      end
    end
  end

endmodule

// File: rtl/msq_window_sum.sv
module msq_window_sum #(
  parameter int unsigned SQ_W    = 32,
  parameter int unsigned WIN_LEN = 120,
  localparam int unsigned ACC_W  = SQ_W + $clog2(WIN_LEN + 1),
  localparam int unsigned PTR_W  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1,
  localparam int unsigned FILL_W = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sq_valid,
  input  logic [SQ_W-1:0]  sq_data,
  output logic             sum_valid,
  output logic             sum_full,
  output logic [ACC_W-1:0] sum_q
);

  localparam logic [PTR_W-1:0]  PTR_LAST = PTR_W'(WIN_LEN - 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(WIN_LEN);

  // Delay line of squares, one write and one read per accepted sample.
  logic [SQ_W-1:0]   line_mem [WIN_LEN];
  logic [SQ_W-1:0]   old_q;
  logic [SQ_W-1:0]   new_q;
  logic [PTR_W-1:0]  wr_ptr;
  logic [FILL_W-1:0] fill_cnt;
  logic              old_live;
  logic              full_d;
  logic              step_v;

  // Read-before-write on the same address; no reset so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (sq_valid) begin
      old_q            <= line_mem[wr_ptr];
      line_mem[wr_ptr] <= sq_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      fill_cnt <= '0;
      old_live <= 1'b0;
      full_d   <= 1'b0;
      step_v   <= 1'b0;
      new_q    <= '0;
    end else begin
      step_v <= sq_valid;
      if (sq_valid) begin
        new_q    <= sq_data;
        old_live <= (fill_cnt == FILL_MAX);
        full_d   <= (fill_cnt >= FILL_MAX - FILL_W'(1));
        if (fill_cnt != FILL_MAX) begin
          fill_cnt <= fill_cnt + FILL_W'(1);
        end
        if (wr_ptr == PTR_LAST) begin
          wr_ptr <= '0;
        end else begin
          wr_ptr <= wr_ptr + PTR_W'(1);
        end
      end
    end
  end

  // Running sum: add the newest square, drop the one leaving the window.
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q     <= '0;
      sum_valid <= 1'b0;
      sum_full  <= 1'b0;
    end else begin
      sum_valid <= step_v;
      if (step_v) begin
        sum_q    <= sum_q + ACC_W'(new_q) - (old_live ? ACC_W'(old_q) : '0);
        sum_full <= full_d;
      end
    end
  end

endmodule

// File: rtl/msq_isqrt.sv
module msq_isqrt #(
  parameter int unsigned ROOT_W = 16,
  localparam int unsigned RAD_W = 2 * ROOT_W
) (
  input  logic [RAD_W-1:0]  radicand,
  output logic [ROOT_W-1:0] root
);

  // One trial bit per stage, most significant first.
  logic [ROOT_W-1:0] part [ROOT_W+1];

  assign part[ROOT_W] = '0;

  for (genvar g = ROOT_W - 1; g >= 0; g--) begin : g_bit
    logic [ROOT_W-1:0] trial;
    logic [RAD_W-1:0]  trial_sq;
    always_comb begin
      trial    = part[g+1] | (ROOT_W'(1) << g);
      trial_sq = RAD_W'(trial) * RAD_W'(trial);
    end
    assign part[g] = (trial_sq <= radicand) ? trial : part[g+1];
  end

  assign root = part[0];

endmodule

// File: rtl/msq_out_stage.sv
module msq_out_stage
  import msq_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned WIN_LEN  = 120,
  parameter int unsigned DECIM    = 200,
  parameter bit          USE_SQRT = 1'b1,
  localparam int unsigned SQ_W    = 2 * SAMPLE_W,
  localparam int unsigned ACC_W   = SQ_W + $clog2(WIN_LEN + 1),
  localparam int unsigned DCNT_W  = (DECIM > 1) ? $clog2(DECIM) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sum_valid,
  input  logic             sum_full,
  input  logic [ACC_W-1:0] sum_q,
  output logic [SQ_W-1:0]  level_mean,
  output logic             level_valid,
  output logic             dec_stb,
  output logic [SQ_W-1:0]  dec_level
);

  localparam out_sel_e      OUT_MODE = USE_SQRT ? OUT_ROOT : OUT_MEAN;
  localparam logic [DCNT_W-1:0] DCNT_LAST = DCNT_W'(DECIM - 1);

  logic [ACC_W-1:0]  quot;
  logic [SQ_W-1:0]   pick;
  logic [DCNT_W-1:0] dec_cnt;
  logic              take;

  always_comb begin
    quot = sum_q / ACC_W'(WIN_LEN);
  end

  if (OUT_MODE == OUT_ROOT) begin : g_root
    logic [SAMPLE_W-1:0] root;
    msq_isqrt #(.ROOT_W(SAMPLE_W)) isqrt_i (
      .radicand (level_mean),
      .root     (root)
    );
    assign pick = SQ_W'(root);
  end else begin : g_mean
    assign pick = level_mean;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_mean  <= '0;
      level_valid <= 1'b0;
      dec_cnt     <= '0;
      take        <= 1'b0;
    end else begin
      take <= sum_valid && (dec_cnt == DCNT_LAST);
      if (sum_valid) begin
        level_mean <= SQ_W'(quot);
        if (sum_full) begin
          level_valid <= 1'b1;
        end
        if (dec_cnt == DCNT_LAST) begin
          dec_cnt <= '0;
        end else begin
          dec_cnt <= dec_cnt + DCNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_stb   <= 1'b0;
      dec_level <= '0;
    end else begin
      dec_stb <= take;
      if (take) begin
        dec_level <= pick;
      end
    end
  end

endmodule

// File: rtl/msq_level_est.sv
module msq_level_est
  import msq_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned WIN_LEN  = 120,
  parameter int unsigned DECIM    = 200,
  parameter bit          USE_SQRT = 1'b1,
  localparam int unsigned SQ_W    = 2 * SAMPLE_W,
  localparam int unsigned ACC_W   = acc_width(SAMPLE_W, WIN_LEN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic [SQ_W-1:0]     level_mean,
  output logic                level_valid,
  output logic                dec_stb,
  output logic [SQ_W-1:0]     dec_level
);

  logic             sq_valid;
  logic [SQ_W-1:0]  sq_data;
  logic             sum_valid;
  logic             sum_full;
  logic [ACC_W-1:0] sum_q;

  msq_square_stage #(.SAMPLE_W(SAMPLE_W)) square_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (smp_valid),
    .in_data  (smp_data),
    .sq_valid (sq_valid),
    .sq_data  (sq_data)
  );

  msq_window_sum #(.SQ_W(SQ_W), .WIN_LEN(WIN_LEN)) window_i (
    .clk       (clk),
    .rst       (rst),
    .sq_valid  (sq_valid),
    .sq_data   (sq_data),
    .sum_valid (sum_valid),
    .sum_full  (sum_full),
    .sum_q     (sum_q)
  );

  msq_out_stage #(
    .SAMPLE_W (SAMPLE_W),
    .WIN_LEN  (WIN_LEN),
    .DECIM    (DECIM),
    .USE_SQRT (USE_SQRT)
  ) out_i (
    .clk         (clk),
    .rst         (rst),
    .sum_valid   (sum_valid),
    .sum_full    (sum_full),
    .sum_q       (sum_q),
    .level_mean  (level_mean),
    .level_valid (level_valid),
    .dec_stb     (dec_stb),
    .dec_level   (dec_level)
  );

endmodule

// File: rtl/msq_level_est_chk.sv
module msq_level_est_chk #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned WIN_LEN  = 120,
  parameter int unsigned DECIM    = 200,
  parameter bit          USE_SQRT = 1'b1,
  localparam int unsigned SQ_W    = 2 * SAMPLE_W
) (
  input logic                clk,
  input logic                rst,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic [SQ_W-1:0]     level_mean,
  input logic                level_valid,
  input logic                dec_stb,
  input logic [SQ_W-1:0]     dec_level
);

  localparam logic [SQ_W-1:0] MAX_SQ = SQ_W'(1) << (SQ_W - 2);

  logic [2*SQ_W-1:0] lo_sq;
  logic [2*SQ_W-1:0] hi_sq;
  always_comb begin
    lo_sq = (2*SQ_W)'(dec_level) * (2*SQ_W)'(dec_level);
    hi_sq = ((2*SQ_W)'(dec_level) + 1) * ((2*SQ_W)'(dec_level) + 1);
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!level_valid && level_mean == '0 && dec_level == '0)); // R1

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    level_valid |=> level_valid); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    level_mean <= MAX_SQ); // R6

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (DECIM > 1 && dec_stb) |=> !dec_stb); // R7

  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dec_stb |-> $stable(dec_level)); // R8

  AST_DEC_ROOT: assert property (@(posedge clk) disable iff (rst)
    (USE_SQRT && dec_stb) |->
      (lo_sq <= (2*SQ_W)'($past(level_mean)) && hi_sq > (2*SQ_W)'($past(level_mean)))); // R8

  AST_DEC_MEAN: assert property (@(posedge clk) disable iff (rst)
    (!USE_SQRT && dec_stb) |-> dec_level == $past(level_mean)); // R8

endmodule

bind msq_level_est msq_level_est_chk #(
  .SAMPLE_W (SAMPLE_W),
  .WIN_LEN  (WIN_LEN),
  .DECIM    (DECIM),
  .USE_SQRT (USE_SQRT)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .smp_valid   (smp_valid),
  .smp_data    (smp_data),
  .level_mean  (level_mean),
  .level_valid (level_valid),
  .dec_stb     (dec_stb),
  .dec_level   (dec_level)
);

// File: tb/msq_level_est_tb_top.sv
`timescale 1ns/1ps
module msq_level_est_tb_top;

  localparam int W  = 6;
  localparam int N  = 5;
  localparam int D  = 7;
  localparam int SQ = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_valid = 1'b0;
  logic [W-1:0]  smp_data = '0;
  logic [SQ-1:0] mean_a, mean_b, lvl_a, lvl_b;
  logic          val_a, val_b, stb_a, stb_b;

  always #2 clk = ~clk;

  msq_level_est #(.SAMPLE_W(W), .WIN_LEN(N), .DECIM(D), .USE_SQRT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .level_mean(mean_a), .level_valid(val_a), .dec_stb(stb_a), .dec_level(lvl_a));

  msq_level_est #(.SAMPLE_W(W), .WIN_LEN(N), .DECIM(D), .USE_SQRT(1'b0)) dut_raw_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .level_mean(mean_b), .level_valid(val_b), .dec_stb(stb_b), .dec_level(lvl_b));

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // Reference model state
  int win [N];
  int wptr, wcount, smp_no, exp_stb, exp_root, exp_raw;
  // Strobe monitor
  int seen_a = 0, seen_b = 0;
  int cap_a = 0, cap_b = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (stb_a) begin seen_a++; cap_a = int'(lvl_a); end
      if (stb_b) begin seen_b++; cap_b = int'(lvl_b); end
    end
  end

  function automatic int model_mean();
    int s = 0;
    for (int i = 0; i < N; i++) s += win[i];
    return s / N;
  endfunction

  function automatic int model_root(int m);
    int r = 0;
    while ((r + 1) * (r + 1) <= m) r++;
    return r;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < N; i++) win[i] = 0;
    wptr = 0; wcount = 0; smp_no = 0; exp_root = 0; exp_raw = 0;
  endtask

  task automatic model_push(int v);
    win[wptr] = v * v;
    wptr = (wptr + 1) % N;
    if (wcount < N) wcount++;
    smp_no++;
    if (smp_no % D == 0) begin
      exp_stb++;
      exp_raw = model_mean();
      exp_root = model_root(exp_raw);
    end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "mean sqrt-build", int'(mean_a), model_mean());
    chk(req, "mean raw-build", int'(mean_b), model_mean());
    chk("R4", "valid", int'(val_a), (wcount == N) ? 1 : 0);
    chk("R4", "valid raw-build", int'(val_b), (wcount == N) ? 1 : 0);
    chk("R7", "strobe count", seen_a, exp_stb);
    chk("R7", "strobe count raw-build", seen_b, exp_stb);
    chk("R8", "root level", cap_a, exp_root);
    chk("R8", "mean level", cap_b, exp_raw);
  endtask

  task automatic drive_gap(int v, string req);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = W'(v);
    model_push(v);
    @(negedge clk);
    smp_valid = 1'b0;
    smp_data  = W'(v * 13 + 5);
    repeat (5) @(negedge clk);
    check_all(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    model_clear();
    chk("R1", "mean in reset", int'(mean_a), 0);
    chk("R1", "valid in reset", int'(val_a), 0);
    chk("R1", "strobe in reset", int'(stb_a), 0);
    chk("R1", "level in reset", int'(lvl_a), 0);
    chk("R1", "raw level in reset", int'(lvl_b), 0);
    cap_a = 0; cap_b = 0;
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "mean after reset", int'(mean_a), 0);
    chk("R1", "valid after reset", int'(val_b), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int m0, s0;
    exp_stb = 0;
    model_clear();
    do_reset();

    // R2 / R3: every input code through the window, first samples partial fill
    for (int v = -32; v < 32; v++) drive_gap(v, (v < -32 + N) ? "R3" : "R2");

    // R10: amplitude step settles within one window
    for (int i = 0; i < N; i++) drive_gap(3, "R10");
    for (int i = 0; i < N; i++) drive_gap(20, "R10");
    chk("R10", "settled level", int'(mean_a), 400);

    // R6: full-scale negative window
    for (int i = 0; i < N; i++) drive_gap(-32, "R6");
    chk("R6", "full-scale mean", int'(mean_b), 1024);

    // R9: back-to-back burst
    @(negedge clk);
    for (int i = 0; i < 23; i++) begin
      smp_valid = 1'b1;
      smp_data  = W'(((i * 7) % 64) - 32);
      model_push(((i * 7) % 64) - 32);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    repeat (6) @(negedge clk);
    check_all("R9");

    // R5: data wiggles with valid low
    m0 = int'(mean_a);
    s0 = seen_a;
    for (int i = 0; i < 20; i++) begin
      smp_data = W'(i * 11);
      @(negedge clk);
    end
    repeat (5) @(negedge clk);
    chk("R5", "mean unchanged", int'(mean_a), m0);
    chk("R5", "strobes unchanged", seen_a, s0);

    // R4: reset mid-run, valid drops and returns after refill
    do_reset();
    for (int i = 0; i < N + 4; i++) drive_gap(i * 4 - 17, "R4");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule